// File: doc/BRIEF.md
# Grouped Special Register File

This block is the special-purpose register bank of a small CPU core. The core reaches it with move-to and move-from operations. The operand address is a 16-bit value: the top five bits select a register group and the low eleven bits select a register inside that group. The block decodes the address and holds the system group registers: version, status, next and previous program counter, exception PC, exception address and exception status. It also holds the per-entry match and translate words of a data translation array and an instruction translation array. Read data goes back to the core combinationally. Flush strobes go out to the translation caches.

Three parts of the block act on their own. A status write always forces the fixed-one bit on. A status write that changes any of the three mode bits pulses a full-flush strobe. A match-word write that clears the valid bit pulses a page-flush strobe, which carries the page address of the match word it replaces. The configuration words are build-time parameters. An address the block does not map reads back the core's previous destination value, and a write to such an address is dropped.

Top module: `sprf_top`

## Requirements
- R1: The effective address is the bitwise OR of `base_addr` and `imm_off`, not their sum. Bits [15:11] give the group and bits [10:0] give the number.
- R2: In group 0, the writable registers are number 16 (next PC), 17 (status), 18 (previous PC), 32 (exception PC), 48 (exception address) and 64 (exception status). Numbers 16, 18, 32, 48 and 64 read back exactly the last value written.
- R3: Every status write stores the written value with bit 15 forced to 1.
- R4: A status write that changes bit 0 (supervisor), bit 5 (data translation enable) or bit 6 (instruction translation enable) drives `tlb_flush_all` high for the one cycle after the write edge. Any other status write leaves it low.
- R5: Data array match words sit at group 1, numbers 512+i, and translate words at numbers 640+i. The instruction array uses the same numbers in group 2. There is one word per entry, and each word reads back the last value written.
- R6: A match-word write with bit 0 clear pulses the array's page-flush output for one cycle after the write edge. The page address output then holds the old match word with its low PAGE_BITS (13) bits cleared. A match-word write with bit 0 set gives no pulse.
- R7: The version register (group 0, number 0) is writable. A read of it returns the stored value ANDed with VER_MASK.
- R8: Group 0 numbers 1 to 4 read the parameters UPR_VAL, CPUCFG_VAL, DMMUCFG_VAL and IMMUCFG_VAL, and writes to them are dropped.
- R9: An unmapped address reads back `rd_prev` and is not changed by writes. Unmapped addresses are: group 1 and 2 numbers from 512+TLB_DEPTH to 639, numbers from 640+TLB_DEPTH up, the range 768 to 1535, unlisted group 0 numbers, and groups 3 to 31.
- R10: A write takes effect on the rising clock edge where `wr_en` is high. A read follows the address in the same cycle, with no clock.
- R11: After reset, status reads 0x8001, version reads VER_RESET & VER_MASK, and every other stored register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | 16 | Base register part of the address |
| imm_off | input | 16 | Immediate offset part of the address |
| wr_en | input | 1 | Move-to strobe, sampled at the rising edge |
| wr_data | input | 32 | Move-to data |
| rd_prev | input | 32 | Previous destination value, returned for unmapped reads |
| rd_data | output | 32 | Move-from data (combinational) |
| tlb_flush_all | output | 1 | One-cycle full translation flush |
| dtlb_page_flush | output | 1 | One-cycle data-array page flush |
| dtlb_page_addr | output | 32 | Page address for the data-array flush |
| itlb_page_flush | output | 1 | One-cycle instruction-array page flush |
| itlb_page_addr | output | 32 | Page address for the instruction-array flush |

## Verification
Read data is combinational, so each read is driven at a falling edge and sampled 1 ns later, in the same cycle. A write is driven at a falling edge and lands at the next rising edge. Any flush pulse or page address it causes is registered at that same edge, so the bench checks these outputs at the following falling edge. It then checks them again after the next write, where a stale pulse would show as a failure. Stored values are compared through later reads against a model held in the bench, and the model is updated in program order.

// File: rtl/sprf_pkg.sv
package sprf_pkg;
  localparam int ADDR_W = 16;
  localparam int GRP_W  = 5;
  localparam int NUM_W  = 11;

  // status bit positions that other logic depends on
  localparam int ST_SUPER = 0;
  localparam int ST_DXLT  = 5;
  localparam int ST_IXLT  = 6;
  localparam int ST_ONE   = 15;

  localparam int MATCH_BASE = 512;
  localparam int XLAT_BASE  = 640;

  typedef enum logic [3:0] {
    K_NONE, K_VER, K_UNITS, K_CORECFG, K_DXCFG, K_IXCFG,
    K_NEXTPC, K_STATUS, K_PREVPC, K_EXCPC, K_EXCADDR, K_EXCSTAT,
    K_DMATCH, K_DXLAT, K_IMATCH, K_IXLAT
  } spr_kind_e;

  localparam int N_PLAIN = 6;

  function automatic spr_kind_e plain_kind(input int g);
    case (g)
      0:       return K_VER;
      1:       return K_NEXTPC;
      2:       return K_PREVPC;
      3:       return K_EXCPC;
      4:       return K_EXCADDR;
      default: return K_EXCSTAT;
    endcase
  endfunction
endpackage

// File: rtl/sprf_decode.sv
module sprf_decode
  import sprf_pkg::*;
#(
  parameter int TLB_DEPTH = 16,
  parameter int IDX_W     = $clog2(TLB_DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output spr_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [NUM_W-1:0] M_LO = NUM_W'(MATCH_BASE);
  localparam logic [NUM_W-1:0] M_HI = NUM_W'(MATCH_BASE + TLB_DEPTH);
  localparam logic [NUM_W-1:0] X_LO = NUM_W'(XLAT_BASE);
  localparam logic [NUM_W-1:0] X_HI = NUM_W'(XLAT_BASE + TLB_DEPTH);

  logic [GRP_W-1:0] grp;
  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] m_off;
  logic [NUM_W-1:0] x_off;
  logic             in_match;
  logic             in_xlat;

  assign grp      = addr[ADDR_W-1:NUM_W];
  assign num      = addr[NUM_W-1:0];
  assign m_off    = num - M_LO;
  assign x_off    = num - X_LO;
  assign in_match = (num >= M_LO) && (num < M_HI);
  assign in_xlat  = (num >= X_LO) && (num < X_HI);

  always_comb begin
    kind = K_NONE;
    idx  = '0;
    case (grp)
      GRP_W'(0): begin
        case (num)
          NUM_W'(0):  kind = K_VER;
          NUM_W'(1):  kind = K_UNITS;
          NUM_W'(2):  kind = K_CORECFG;
          NUM_W'(3):  kind = K_DXCFG;
          NUM_W'(4):  kind = K_IXCFG;
          NUM_W'(16): kind = K_NEXTPC;
          NUM_W'(17): kind = K_STATUS;
          NUM_W'(18): kind = K_PREVPC;
          NUM_W'(32): kind = K_EXCPC;
          NUM_W'(48): kind = K_EXCADDR;
          NUM_W'(64): kind = K_EXCSTAT;
          default:    kind = K_NONE;
        endcase
      end
      GRP_W'(1), GRP_W'(2): begin
        if (in_match) begin
          kind = (grp == GRP_W'(1)) ? K_DMATCH : K_IMATCH;
          idx  = m_off[IDX_W-1:0];
        end else if (in_xlat) begin
          kind = (grp == GRP_W'(1)) ? K_DXLAT : K_IXLAT;
          idx  = x_off[IDX_W-1:0];
        end
      end
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/sprf_sys_regs.sv
module sprf_sys_regs
  import sprf_pkg::*;
#(
  parameter int              DW        = 32,
  parameter logic [DW-1:0]   VER_RESET = 32'h1200_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  spr_kind_e     kind,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] plain_q [N_PLAIN],
  output logic [DW-1:0] status_q,
  output logic          flush_all
);
  localparam logic [DW-1:0] ONE_BIT   = DW'(1) << ST_ONE;
  localparam logic [DW-1:0] MODE_MASK = (DW'(1) << ST_SUPER) |
                                        (DW'(1) << ST_DXLT)  |
                                        (DW'(1) << ST_IXLT);
  localparam logic [DW-1:0] ST_RESET  = ONE_BIT | (DW'(1) << ST_SUPER);

  logic st_we;
  logic mode_change;

  assign st_we       = wr_en && (kind == K_STATUS);
  assign mode_change = ((status_q ^ wdata) & MODE_MASK) != '0;

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    localparam spr_kind_e MY_KIND = plain_kind(g);
    localparam logic [DW-1:0] MY_RST = (g == 0) ? VER_RESET : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            plain_q[g] <= MY_RST;
      else if (wr_en && (kind == MY_KIND))   plain_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= ST_RESET;
      flush_all <= 1'b0;
    end else begin
      flush_all <= st_we && mode_change;
      if (st_we) status_q <= wdata | ONE_BIT;
    end
  end

  assert_status_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> (status_q == ($past(wdata) | ONE_BIT)));

  assert_full_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && (((status_q ^ wdata) & MODE_MASK) != '0)) |=> flush_all);

  assert_no_full_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_we && (((status_q ^ wdata) & MODE_MASK) != '0)) |=> !flush_all);
endmodule

// File: rtl/sprf_tlb_bank.sv
module sprf_tlb_bank #(
  parameter int DW        = 32,
  parameter int DEPTH     = 16,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             match_we,
  input  logic             xlat_we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    match_rd,
  output logic [DW-1:0]    xlat_rd,
  output logic             page_flush,
  output logic [DW-1:0]    page_addr
);
  localparam logic [DW-1:0] PAGE_MASK = {DW{1'b1}} << PAGE_BITS;

  logic [DW-1:0] match_q [DEPTH];
  logic [DW-1:0] xlat_q  [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        match_q[e] <= '0;
        xlat_q[e]  <= '0;
      end else begin
        if (match_we && (idx == IDX_W'(e))) match_q[e] <= wdata;
        if (xlat_we  && (idx == IDX_W'(e))) xlat_q[e]  <= wdata;
      end
    end
  end

  assign match_rd = match_q[idx];
  assign xlat_rd  = xlat_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_flush <= 1'b0;
      page_addr  <= '0;
    end else begin
      page_flush <= match_we && !wdata[0];
      if (match_we && !wdata[0]) page_addr <= match_rd & PAGE_MASK;
    end
  end

  assert_match_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_we |=> (match_q[$past(idx)] == $past(wdata)));

  assert_xlat_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_we |=> (xlat_q[$past(idx)] == $past(wdata)));

  assert_page_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_we && !wdata[0]) |=> (page_flush && (page_addr == ($past(match_rd) & PAGE_MASK))));

  assert_valid_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_we && !wdata[0]) |=> !page_flush);
endmodule

// File: rtl/sprf_top.sv
module sprf_top
  import sprf_pkg::*;
#(
  parameter int            DW          = 32,
  parameter int            TLB_DEPTH   = 16,
  parameter int            PAGE_BITS   = 13,
  parameter logic [31:0]   VER_MASK    = 32'hFFFF_003F,
  parameter logic [31:0]   VER_RESET   = 32'h1200_0001,
  parameter logic [31:0]   UPR_VAL     = 32'h0000_0619,
  parameter logic [31:0]   CPUCFG_VAL  = 32'h0000_0020,
  parameter logic [31:0]   DMMUCFG_VAL = 32'h0000_0018,
  parameter logic [31:0]   IMMUCFG_VAL = 32'h0000_0019
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   base_addr,
  input  logic [15:0]   imm_off,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [31:0]   rd_prev,
  output logic [31:0]   rd_data,
  output logic          tlb_flush_all,
  output logic          dtlb_page_flush,
  output logic [31:0]   dtlb_page_addr,
  output logic          itlb_page_flush,
  output logic [31:0]   itlb_page_addr
);
  localparam int IDX_W = $clog2(TLB_DEPTH);

  logic [ADDR_W-1:0] eff_addr;
  spr_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [DW-1:0]     plain_q [N_PLAIN];
  logic [DW-1:0]     status_q;
  logic [DW-1:0]     match_rd [2];
  logic [DW-1:0]     xlat_rd  [2];
  logic              pflush   [2];
  logic [DW-1:0]     paddr    [2];

  assign eff_addr = base_addr | imm_off;

  sprf_decode #(.TLB_DEPTH(TLB_DEPTH), .IDX_W(IDX_W)) decode_i (
    .addr (eff_addr),
    .kind (kind),
    .idx  (idx)
  );

  sprf_sys_regs #(.DW(DW), .VER_RESET(VER_RESET)) sys_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .kind      (kind),
    .wdata     (wr_data),
    .plain_q   (plain_q),
    .status_q  (status_q),
    .flush_all (tlb_flush_all)
  );

  for (genvar k = 0; k < 2; k++) begin : g_bank
    localparam spr_kind_e MK = (k == 0) ? K_DMATCH : K_IMATCH;
    localparam spr_kind_e XK = (k == 0) ? K_DXLAT  : K_IXLAT;
    sprf_tlb_bank #(.DW(DW), .DEPTH(TLB_DEPTH), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .match_we   (wr_en && (kind == MK)),
      .xlat_we    (wr_en && (kind == XK)),
      .idx        (idx),
      .wdata      (wr_data),
      .match_rd   (match_rd[k]),
      .xlat_rd    (xlat_rd[k]),
      .page_flush (pflush[k]),
      .page_addr  (paddr[k])
    );
  end

  assign dtlb_page_flush = pflush[0];
  assign dtlb_page_addr  = paddr[0];
  assign itlb_page_flush = pflush[1];
  assign itlb_page_addr  = paddr[1];

  always_comb begin
    case (kind)
      K_VER:     rd_data = plain_q[0] & VER_MASK;
      K_UNITS:   rd_data = UPR_VAL;
      K_CORECFG: rd_data = CPUCFG_VAL;
      K_DXCFG:   rd_data = DMMUCFG_VAL;
      K_IXCFG:   rd_data = IMMUCFG_VAL;
      K_NEXTPC:  rd_data = plain_q[1];
      K_STATUS:  rd_data = status_q;
      K_PREVPC:  rd_data = plain_q[2];
      K_EXCPC:   rd_data = plain_q[3];
      K_EXCADDR: rd_data = plain_q[4];
      K_EXCSTAT: rd_data = plain_q[5];
      K_DMATCH:  rd_data = match_rd[0];
      K_DXLAT:   rd_data = xlat_rd[0];
      K_IMATCH:  rd_data = match_rd[1];
      K_IXLAT:   rd_data = xlat_rd[1];
      default:   rd_data = rd_prev;
    endcase
  end

  assert_flush_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dtlb_page_flush && itlb_page_flush));
endmodule

// File: tb/sprf_top_tb_top.sv
module sprf_top_tb_top;
  localparam int          D      = 16;
  localparam logic [31:0] VMASK  = 32'hFFFF_003F;
  localparam logic [31:0] VRST   = 32'h1200_0001;
  localparam logic [31:0] C_UPR  = 32'h0000_0619;
  localparam logic [31:0] C_CPU  = 32'h0000_0020;
  localparam logic [31:0] C_DMMU = 32'h0000_0018;
  localparam logic [31:0] C_IMMU = 32'h0000_0019;
  localparam logic [31:0] PMASK  = 32'hFFFF_E000;
  localparam logic [31:0] MODEM  = 32'h0000_0061;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] base_addr = '0, imm_off = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0, rd_prev = '0;
  logic [31:0] rd_data;
  logic tlb_flush_all, dtlb_page_flush, itlb_page_flush;
  logic [31:0] dtlb_page_addr, itlb_page_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sprf_top #(.TLB_DEPTH(D), .PAGE_BITS(13), .VER_MASK(VMASK), .VER_RESET(VRST),
             .UPR_VAL(C_UPR), .CPUCFG_VAL(C_CPU), .DMMUCFG_VAL(C_DMMU),
             .IMMUCFG_VAL(C_IMMU)) dut_i (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .imm_off(imm_off),
    .wr_en(wr_en), .wr_data(wr_data), .rd_prev(rd_prev), .rd_data(rd_data),
    .tlb_flush_all(tlb_flush_all), .dtlb_page_flush(dtlb_page_flush),
    .dtlb_page_addr(dtlb_page_addr), .itlb_page_flush(itlb_page_flush),
    .itlb_page_addr(itlb_page_addr));

  // bench model
  logic [31:0] m_ver, m_npc, m_st, m_ppc, m_epc, m_eadr, m_est;
  logic [31:0] m_mt [2][D];
  logic [31:0] m_xl [2][D];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [15:0] a, input logic [31:0] prev);
    int g = int'(a[15:11]);
    int n = int'(a[10:0]);
    if (g == 0) begin
      case (n)
        0:  return m_ver & VMASK;
        1:  return C_UPR;
        2:  return C_CPU;
        3:  return C_DMMU;
        4:  return C_IMMU;
        16: return m_npc;
        17: return m_st;
        18: return m_ppc;
        32: return m_epc;
        48: return m_eadr;
        64: return m_est;
        default: return prev;
      endcase
    end else if (g == 1 || g == 2) begin
      if (n >= 512 && n < 512 + D) return m_mt[g-1][n-512];
      if (n >= 640 && n < 640 + D) return m_xl[g-1][n-640];
      return prev;
    end
    return prev;
  endfunction

  task automatic rd(input logic [15:0] a, input logic [31:0] prev, input string req);
    @(negedge clk);
    base_addr = a & 16'hFFF0;
    imm_off   = a & 16'h000F;
    rd_prev   = prev;
    #1;
    check(req, rd_data, exp_read(a, prev));
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    int g = int'(a[15:11]);
    int n = int'(a[10:0]);
    bit efa = 0;
    bit epf [2] = '{0, 0};
    logic [31:0] epa [2] = '{32'h0, 32'h0};
    if (g == 0) begin
      case (n)
        0:  m_ver = d;
        16: m_npc = d;
        17: begin efa = ((m_st ^ d) & MODEM) != 0; m_st = d | 32'h8000; end
        18: m_ppc = d;
        32: m_epc = d;
        48: m_eadr = d;
        64: m_est = d;
        default: ;
      endcase
    end else if (g == 1 || g == 2) begin
      if (n >= 512 && n < 512 + D) begin
        if (!d[0]) begin epf[g-1] = 1; epa[g-1] = m_mt[g-1][n-512] & PMASK; end
        m_mt[g-1][n-512] = d;
      end else if (n >= 640 && n < 640 + D) m_xl[g-1][n-640] = d;
    end
    @(negedge clk);
    base_addr = a & 16'hFFF0;
    imm_off   = a & 16'h000F;
    wr_data   = d;
    wr_en     = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R4 full flush", 32'(tlb_flush_all), 32'(efa));
    check("R6 dtlb flush", 32'(dtlb_page_flush), 32'(epf[0]));
    check("R6 itlb flush", 32'(itlb_page_flush), 32'(epf[1]));
    if (epf[0]) check("R6 dtlb page addr", dtlb_page_addr, epa[0]);
    if (epf[1]) check("R6 itlb page addr", itlb_page_addr, epa[1]);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_ver = VRST; m_npc = 0; m_st = 32'h8001; m_ppc = 0; m_epc = 0; m_eadr = 0; m_est = 0;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < D; i++) begin m_mt[k][i] = 0; m_xl[k][i] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state over group 0 and both arrays
    for (int n = 0; n < 128; n++) rd(16'(n), 32'hA500_0000 | 32'(n), "R11 reset g0");
    for (int n = 512; n < 512 + D; n++) begin
      rd(16'h0800 | 16'(n), 32'h1, "R11 reset dtlb");
      rd(16'h1000 | 16'(n + 128), 32'h2, "R11 reset itlb");
    end
    check("R11 status reset", exp_read(16'd17, 0), 32'h8001);

    // R2, R7, R8, R10: group 0 writes then reads
    wr(16'd16, 32'h0000_1000); wr(16'd18, 32'h0000_0FFC);
    wr(16'd32, 32'hDEAD_BEEF); wr(16'd48, 32'h8000_0001);
    wr(16'd64, 32'h0000_0203); wr(16'd0, 32'hFFFF_FFFF);
    for (int n = 1; n <= 4; n++) wr(16'(n), 32'h5555_5555);
    for (int n = 0; n <= 64; n++) rd(16'(n), 32'h7700_0000 | 32'(n), "R2 R7 R8 readback");
    check("R7 version masked", exp_read(16'd0, 0), VMASK);

    // R3, R4: status writes, mode changes and non-changes
    wr(16'd17, 32'h0000_0000); rd(16'd17, 0, "R3 status forced bit");
    wr(16'd17, 32'h0000_0002); rd(16'd17, 0, "R3 status");
    wr(16'd17, 32'h0000_0022);
    wr(16'd17, 32'h0000_0062);
    wr(16'd17, 32'h0000_0063);
    wr(16'd17, 32'h0000_8063); rd(16'd17, 0, "R3 status");
    wr(16'd17, 32'hFFFF_FF9C); rd(16'd17, 0, "R3 status all");

    // R1: OR, not add (0x0011 | 0x0001 = status; a sum would reach number 18)
    @(negedge clk);
    base_addr = 16'h0011; imm_off = 16'h0001; wr_data = 32'h0000_0063; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_st = 32'h0000_8063;
    base_addr = 16'h0012; imm_off = 16'h0000; #1;
    check("R1 OR addressing leaves prev pc", rd_data, m_ppc);
    base_addr = 16'h0010; imm_off = 16'h0001; #1;
    check("R1 OR addressing hits status", rd_data, m_st);

    // R5, R6: fill both arrays, then invalidate
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < D; i++) begin
        wr(16'((k + 1) << 11) | 16'(512 + i), ((32'(i) + 1 + 32'(k) * 32) << 13) | 32'h0A51);
        wr(16'((k + 1) << 11) | 16'(640 + i), 32'hC000_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(k));
      end
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < D; i++) begin
        rd(16'((k + 1) << 11) | 16'(512 + i), 0, "R5 match readback");
        rd(16'((k + 1) << 11) | 16'(640 + i), 0, "R5 xlat readback");
      end
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < D; i++)
        wr(16'((k + 1) << 11) | 16'(512 + i), (32'(i) << 13) | 32'h0100);

    // R9: write sweep over the whole translation window, then read sweep
    for (int k = 1; k <= 2; k++)
      for (int n = 512; n < 1536; n++)
        wr(16'(k << 11) | 16'(n), {16'(n), 16'h5A5B ^ 16'(k)});
    for (int k = 1; k <= 2; k++)
      for (int n = 512; n < 1536; n++)
        rd(16'(k << 11) | 16'(n), 32'hB000_0000 | 32'(n), "R9 window read");
    for (int n = 65; n < 2048; n += 7) begin
      wr(16'(n), 32'hFACE_0000 | 32'(n));
      rd(16'(n), 32'hE100_0000 | 32'(n), "R9 group0 unmapped");
    end
    for (int g = 3; g < 32; g++) begin
      wr(16'(g << 11) | 16'd17, 32'h0000_0000);
      rd(16'(g << 11) | 16'd17, 32'(g), "R9 other group");
      rd(16'(g << 11) | 16'd512, 32'(g) + 1, "R9 other group");
    end
    for (int n = 0; n <= 64; n++) rd(16'(n), 32'h3300_0000, "R9 group0 intact");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule